// File: doc/BRIEF.md
# Shared-Converter Successive-Approximation Sequencer

This block is the digital controller for one 10-bit successive-approximation converter that serves eight input channels through an analog multiplexer. Each channel is marked analog or digital by a 4-bit configuration code held in the block. A start request names a channel. If that channel is analog, the block steers the multiplexer to it and waits a fixed settling time so the sampling network can charge. It then searches the code space one bit per clock, starting at the most significant bit.

On each trial the block drives a code to the internal DAC. An external comparator answers whether the sampled input is at or above that code. When the last bit has been decided, the final code goes into a result register and a one-cycle done pulse is raised. A start on a channel that is configured as digital is refused with a one-cycle error pulse. A start that arrives while a conversion is in progress is dropped.

Top module: `sar_mux_ctrl`

## Requirements
- R1: After reset, busy, done and err are 0, result is 0, dac_code is 0, and the configuration code is 0000, which marks all eight channels analog.
- R2: A clock edge with cfg_we high loads cfg_code. The analog channels for each code are:
  - 0000, 0001 and 1000: all eight channels.
  - 0010, 0011 and 1100: channels 0 to 4.
  - 0100 and 0101: channels 0, 1 and 3.
  - 0110 and 0111: none.
  - 1001, 1010 and 1011: channels 0 to 5.
  - 1101: channels 0 to 3.
  - 1110: channel 0 only.
  - 1111: channels 0, 2 and 3.
- R3: A start sampled while idle on a channel the current code marks digital raises err for exactly one cycle. It starts no conversion (busy stays 0) and leaves result unchanged.
- R4: A start sampled while idle on an analog channel sets mux_sel to that channel and raises busy. The block then holds dac_code at 0 for ACQ_CYCLES cycles of acquisition. mux_sel stays constant while busy, and dac_code is 0 whenever the block is idle.
- R5: The first cycle after acquisition drives dac_code = 2^(RES_W-1), and each following cycle decides one bit, from the most significant bit downward.
- R6: result becomes the largest code not above the input, where a trial bit is kept when cmp_keep is 1. done is high for exactly one cycle. With the start sampled at edge k, done and the new result are visible after edge k+ACQ_CYCLES+RES_W.
- R7: result holds its value in every cycle except the one in which done is raised.
- R8: A start that arrives while busy is ignored: it raises no err, and it changes neither mux_sel nor the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load cfg_code into the configuration register |
| cfg_code | input | 4 | Analog/digital configuration code |
| chan_sel | input | 3 | Channel requested with start |
| start | input | 1 | Conversion request |
| cmp_keep | input | 1 | Comparator: input is at or above dac_code |
| mux_sel | output | 3 | Channel connected through the multiplexer |
| dac_code | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | Acquisition or conversion in progress |
| done | output | 1 | One-cycle pulse when a result is stored |
| err | output | 1 | One-cycle pulse on a refused start |
| result | output | 10 | Last conversion result |

## Verification
A corrupted trial register or bit pointer shows up as a wrong final code, or as done arriving at the wrong latency. Both become visible at the ports within ACQ_CYCLES plus RES_W cycles of the start. A wrong acquisition count shifts the cycle in which the first trial code of 512 appears. A bad configuration decode shows up as an err pulse one cycle after a start, or as a missing err pulse. Stray updates of the result register appear as changes in result while done is low, and stray updates of the selected channel appear as changes in mux_sel while busy is high.

// File: rtl/sar_mux_pkg.sv
`timescale 1ns/1ps
package sar_mux_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_cfg_decode.sv
`timescale 1ns/1ps
module sar_cfg_decode #(
  parameter int NUM_CH = 8,
  parameter int CFG_W  = 4
) (
  input  logic [CFG_W-1:0]  cfg,
  output logic [NUM_CH-1:0] analog_mask
);
  // Number of leading analog channels (0..NUM_CH) or a sparse pattern.
  logic [NUM_CH-1:0] low_run [0:NUM_CH];

  // Contiguous-run masks: low_run[n] has channels 0..n-1 analog.
  for (genvar n = 0; n <= NUM_CH; n++) begin : g_run
    for (genvar b = 0; b < NUM_CH; b++) begin : g_bit
      assign low_run[n][b] = (b < n);
    end
  end

  always_comb begin
    analog_mask = '0;
    case (cfg[3:0])
      4'b0000, 4'b0001, 4'b1000: analog_mask = low_run[NUM_CH];
      4'b0010, 4'b0011, 4'b1100: analog_mask = low_run[5];
      4'b0100, 4'b0101: begin
        analog_mask    = '0;
        analog_mask[0] = 1'b1;
        analog_mask[1] = 1'b1;
        analog_mask[3] = 1'b1;
      end
      4'b0110, 4'b0111: analog_mask = '0;
      4'b1001, 4'b1010, 4'b1011: analog_mask = low_run[6];
      4'b1101: analog_mask = low_run[4];
      4'b1110: analog_mask = low_run[1];
      4'b1111: begin
        analog_mask    = '0;
        analog_mask[0] = 1'b1;
        analog_mask[2] = 1'b1;
        analog_mask[3] = 1'b1;
      end
      default: analog_mask = '0;
    endcase
  end
endmodule

// File: rtl/sar_acq_timer.sv
`timescale 1ns/1ps
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(ACQ_CYCLES + 1) + 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ACQ_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/sar_approx_reg.sv
`timescale 1ns/1ps
module sar_approx_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             keep,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] final_code,
  output logic             last
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] acc_q, acc_d;
  logic [RES_W-1:0] ptr_q, ptr_d;
  logic             reg_en;

  assign trial = acc_q | ptr_q;

  always_comb begin
    acc_d  = acc_q;
    ptr_d  = ptr_q;
    reg_en = 1'b0;
    if (init) begin
      acc_d  = '0;
      ptr_d  = TOP_BIT;
      reg_en = 1'b1;
    end else if (step) begin
      acc_d  = keep ? trial : acc_q;
      ptr_d  = ptr_q >> 1;
      reg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ptr_q <= '0;
    end else if (reg_en) begin
      acc_q <= acc_d;
      ptr_q <= ptr_d;
    end
  end

  assign final_code = keep ? trial : acc_q;
  assign last       = ptr_q[0];
endmodule

// File: rtl/sar_mux_ctrl.sv
`timescale 1ns/1ps
module sar_mux_ctrl #(
  parameter int RES_W      = 10,
  parameter int NUM_CH     = 8,
  parameter int CFG_W      = 4,
  parameter int ACQ_CYCLES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_W-1:0]          cfg_code,
  input  logic [$clog2(NUM_CH)-1:0] chan_sel,
  input  logic                      start,
  input  logic                      cmp_keep,
  output logic [$clog2(NUM_CH)-1:0] mux_sel,
  output logic [RES_W-1:0]          dac_code,
  output logic                      busy,
  output logic                      done,
  output logic                      err,
  output logic [RES_W-1:0]          result
);
  import sar_mux_pkg::*;

  localparam int CH_W = $clog2(NUM_CH);

  sar_state_e        state_q, state_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [RES_W-1:0]  result_q, result_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              chan_en, result_en;

  logic [NUM_CH-1:0] analog_mask;
  logic              acq_load, acq_run, acq_expired;
  logic              sar_init, sar_step, sar_last;
  logic [RES_W-1:0]  sar_trial, sar_final;

  sar_cfg_decode #(.NUM_CH(NUM_CH), .CFG_W(CFG_W)) u_decode (
    .cfg         (cfg_q),
    .analog_mask (analog_mask)
  );

  sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (acq_load),
    .run     (acq_run),
    .expired (acq_expired)
  );

  sar_approx_reg #(.RES_W(RES_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .init       (sar_init),
    .step       (sar_step),
    .keep       (cmp_keep),
    .trial      (sar_trial),
    .final_code (sar_final),
    .last       (sar_last)
  );

  assign acq_run = (state_q == ST_ACQ);

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    chan_d    = chan_q;
    chan_en   = 1'b0;
    result_d  = result_q;
    result_en = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    acq_load  = 1'b0;
    sar_init  = 1'b0;
    sar_step  = 1'b0;
    cfg_d     = cfg_we ? cfg_code : cfg_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (analog_mask[chan_sel]) begin
            state_d  = ST_ACQ;
            chan_d   = chan_sel;
            chan_en  = 1'b1;
            acq_load = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_ACQ: begin
        if (acq_expired) begin
          state_d  = ST_CONV;
          sar_init = 1'b1;
        end
      end
      ST_CONV: begin
        sar_step = 1'b1;
        if (sar_last) begin
          result_d  = sar_final;
          result_en = 1'b1;
          done_d    = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (chan_en) begin
      chan_q <= chan_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (result_en) begin
      result_q <= result_d;
    end
  end

  assign mux_sel  = chan_q;
  assign dac_code = (state_q == ST_CONV) ? sar_trial : '0;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign result   = result_q;
endmodule

// File: rtl/sar_mux_ctrl_chk.sv
`timescale 1ns/1ps
module sar_mux_ctrl_chk #(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      busy,
  input logic                      done,
  input logic                      err,
  input logic [$clog2(NUM_CH)-1:0] mux_sel,
  input logic [RES_W-1:0]          dac_code,
  input logic [RES_W-1:0]          result
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_err_no_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_mux_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));

  assert_idle_dac_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err);
endmodule

bind sar_mux_ctrl sar_mux_ctrl_chk #(.RES_W(RES_W), .NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .mux_sel  (mux_sel),
  .dac_code (dac_code),
  .result   (result)
);

// File: tb/sar_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_mux_ctrl_tb_top;
  localparam int W   = 10;
  localparam int ACQ = 6;
  localparam int MAXV = (1 << W) - 1;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [3:0] cfg_code;
  logic [2:0] chan_sel;
  logic       start;
  logic       cmp_keep;
  logic [2:0] mux_sel;
  logic [W-1:0] dac_code;
  logic       busy, done, err;
  logic [W-1:0] result;

  int   vin;
  int   n_chk;
  int   n_fail;
  bit   finished;
  logic [3:0] cur_cfg;

  assign cmp_keep = (int'(dac_code) <= vin);

  sar_mux_ctrl #(.RES_W(W), .NUM_CH(8), .CFG_W(4), .ACQ_CYCLES(ACQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .chan_sel(chan_sel), .start(start), .cmp_keep(cmp_keep),
    .mux_sel(mux_sel), .dac_code(dac_code), .busy(busy), .done(done),
    .err(err), .result(result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Analog mask per configuration code, from R2.
  function automatic logic [7:0] mask_fn(input logic [3:0] c);
    case (c)
      4'b0000, 4'b0001, 4'b1000: return 8'hFF;
      4'b0010, 4'b0011, 4'b1100: return 8'h1F;
      4'b0100, 4'b0101:          return 8'h0B;
      4'b0110, 4'b0111:          return 8'h00;
      4'b1001, 4'b1010, 4'b1011: return 8'h3F;
      4'b1101:                   return 8'h0F;
      4'b1110:                   return 8'h01;
      default:                   return 8'h0D;
    endcase
  endfunction

  function automatic int expect_code(input int v);
    if (v < 0) return 0;
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  task automatic write_cfg(input logic [3:0] c);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_code = c;
    @(negedge clk);
    cfg_we   = 1'b0;
    cur_cfg  = c;
  endtask

  task automatic run_conv(input int ch, input int v, input bit inject);
    logic [W-1:0] prev;
    bit  exp_err;
    int  cnt;
    @(negedge clk);
    prev     = result;
    exp_err  = !mask_fn(cur_cfg)[ch];
    chan_sel = 3'(ch);
    vin      = v;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start    = 1'b0;
    if (exp_err) begin
      chk(err == 1'b1, "R3", "err on digital channel", int'(err), 1);
      chk(busy == 1'b0, "R3", "busy after refused start", int'(busy), 0);
      @(negedge clk);
      chk(err == 1'b0, "R3", "err width", int'(err), 0);
      chk(result == prev, "R3", "result after refused start", int'(result), int'(prev));
      chk(done == 1'b0, "R3", "done after refused start", int'(done), 0);
      return;
    end
    chk(err == 1'b0, "R3", "err on analog channel", int'(err), 0);
    cnt = 1;
    while (!done && cnt < ACQ + W + 6) begin
      if (cnt <= ACQ) begin
        chk(busy == 1'b1, "R4", "busy in acquisition", int'(busy), 1);
        chk(mux_sel == 3'(ch), "R4", "mux_sel", int'(mux_sel), ch);
        chk(dac_code == '0, "R4", "dac during acquisition", int'(dac_code), 0);
      end
      if (cnt == ACQ + 1)
        chk(dac_code == W'(1 << (W - 1)), "R5", "first trial code", int'(dac_code), 1 << (W - 1));
      if (cnt == ACQ + 2)
        chk(dac_code[W-2] == 1'b1, "R5", "second trial bit set", int'(dac_code[W-2]), 1);
      if (cnt == ACQ + 3)
        chk(result == prev, "R7", "result held mid conversion", int'(result), int'(prev));
      if (inject && cnt == 3) begin
        start    = 1'b1;
        chan_sel = 3'(ch ^ 1);
      end
      if (inject && cnt == 4) begin
        start    = 1'b0;
        chan_sel = 3'(ch);
        chk(err == 1'b0, "R8", "err on busy start", int'(err), 0);
        chk(mux_sel == 3'(ch), "R8", "mux after busy start", int'(mux_sel), ch);
      end
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    chk(done == 1'b1, "R6", "done seen", int'(done), 1);
    chk(cnt == ACQ + W + 1, "R6", "done latency", cnt, ACQ + W + 1);
    chk(int'(result) == expect_code(v), "R6", "result code", int'(result), expect_code(v));
    @(negedge clk);
    chk(done == 1'b0, "R6", "done width", int'(done), 0);
    chk(busy == 1'b0, "R6", "busy after done", int'(busy), 0);
    chk(int'(result) == expect_code(v), "R7", "result held after done", int'(result), expect_code(v));
  endtask

  initial begin
    int seed_dummy;
    n_chk    = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    cfg_we   = 1'b0;
    cfg_code = 4'b0000;
    chan_sel = 3'd0;
    start    = 1'b0;
    vin      = 0;
    cur_cfg  = 4'b0000;
    seed_dummy = $urandom(32'h5EED_0A11);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(err == 1'b0, "R1", "err after reset", int'(err), 0);
    chk(result == '0, "R1", "result after reset", int'(result), 0);
    chk(dac_code == '0, "R1", "dac after reset", int'(dac_code), 0);
    // R1: every channel analog by default
    run_conv(7, 300, 1'b0);
    run_conv(5, 1023, 1'b0);
    run_conv(0, 0, 1'b0);
    run_conv(3, 1500, 1'b0);
    run_conv(2, 512, 1'b0);
    run_conv(6, 511, 1'b0);
    run_conv(1, 682, 1'b0);
    // R2: code 0010 makes channels 5..7 digital
    write_cfg(4'b0010);
    run_conv(5, 100, 1'b0);
    run_conv(7, 100, 1'b0);
    run_conv(4, 100, 1'b0);
    // R2 / R3: all-digital code
    write_cfg(4'b0110);
    run_conv(0, 50, 1'b0);
    // R2: sparse code
    write_cfg(4'b0100);
    run_conv(2, 77, 1'b0);
    run_conv(3, 77, 1'b0);
    // R8: start while busy is ignored
    write_cfg(4'b0000);
    run_conv(4, 345, 1'b1);
    run_conv(1, 1, 1'b1);
    // Random mix
    for (int i = 0; i < 80; i++) begin
      if (($urandom % 4) == 0) write_cfg(4'($urandom % 16));
      run_conv(int'($urandom % 8), int'($urandom % 1200), bit'($urandom % 3 == 0));
    end
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule